// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a processor and memory. The processor issues one 32-bit word read or write at a time, with a byte-lane mask for writes. It holds the request until the cache answers with a single-cycle ready pulse. The cache stores 128 lines of 32 bytes, which is 4 KB. Each line keeps a tag, a valid flag and a modified flag. Hits are served from the local arrays, and memory sees no traffic for them.

On a miss, a small controller talks to memory one line at a time. Each memory transaction is a burst of eight word beats, and the words go in ascending address order. If the line being replaced holds modified data, that data is first copied out to memory. The requested line is then fetched. Write misses allocate the line: after the fetch, the store is applied to the fresh copy, as it would be on a write hit.

Top module: `dmc_top`

## Requirements
- R1: Reset clears every valid and modified flag. Right after reset, cpu_ready and mem_req are low. The first access to any address after reset fetches its line, and modified data held before reset is never copied out.
- R2: The byte address is decoded as follows: tag is bits [31:12], line index is bits [11:5], word within the line is bits [4:2], and bits [1:0] are ignored. mem_addr always carries the byte address of the start of the line, so its bits [4:0] are zero.
- R3: A read that finds a valid line with a matching tag returns the stored word with cpu_ready high in the second cycle after the request is taken. There is no memory traffic.
- R4: A write hit updates only the byte lanes whose cpu_be bit is set, with cpu_be[i] selecting bits [8i+7:8i]. It marks the line modified and does not write memory. The response timing is the same as for a read hit.
- R5: A miss on an invalid line or an unmodified line performs exactly one read burst of eight beats from the requested line. cpu_ready comes in the eleventh cycle when memory acknowledges every beat.
- R6: A miss on a modified line first writes all eight words of the old line to the line address formed from the old tag. It then reads the new line. cpu_ready comes in the nineteenth cycle when every beat is acknowledged.
- R7: A write miss fetches the line and then merges the write under cpu_be. The line is left modified.
- R8: Two addresses with the same index and different tags evict each other. Returning to the first address misses again and returns its latest value.
- R9: cpu_ready is high for exactly one cycle per request. It stays low from the request until the response.
- R10: During a burst, mem_req, mem_we and mem_addr stay unchanged until the beat is acknowledged. Beat k carries the word at mem_addr + 4k, and beats advance only on mem_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_be | input | 4 | Byte-lane mask for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory burst in progress |
| mem_we | output | 1 | 1 for a write-back burst, 0 for a fetch |
| mem_addr | output | 32 | Line start byte address |
| mem_wdata | output | 32 | Write-back word of the current beat |
| mem_rdata | input | 32 | Fetched word of the current beat |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
The bench drives each request on a falling edge and counts falling edges until cpu_ready appears. It expects the pulse at exactly 2 cycles for a hit, 11 cycles for a fetch-only miss and 19 cycles for a miss that copies out first. This holds because the bench memory acknowledges every beat in the cycle it is raised. Memory beats are logged on falling edges, one per cycle in which mem_req and mem_ack are both high. Each access is then checked for its number of copy-out and fetch beats and the start addresses of those bursts. Read data is sampled in the same half-cycle as the ready pulse. It is compared with a byte-merged shadow of every write the bench has issued.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOOKUP    = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_REFILL    = 3'd3,
        ST_RESPOND   = 3'd4
    } state_e;

    typedef struct packed {
        logic install;
        logic set_dirty;
    } tag_op_t;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W     = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] idx,
    input  dmc_pkg::tag_op_t             op,
    input  logic [TAG_W-1:0]             new_tag,
    output logic [TAG_W-1:0]             rd_tag,
    output logic                         rd_valid,
    output logic                         rd_dirty
);

    typedef struct packed {
        logic [NUM_LINES-1:0] valid;
        logic [NUM_LINES-1:0] dirty;
    } flags_t;

    flags_t flags_d, flags_q;
    logic [TAG_W-1:0] tags [NUM_LINES];

    always_comb begin
        flags_d = flags_q;
        if (op.install) begin
            flags_d.valid[idx] = 1'b1;
            flags_d.dirty[idx] = 1'b0;
        end
        if (op.set_dirty) begin
            flags_d.dirty[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_ff @(posedge clk) begin
        if (op.install) begin
            tags[idx] <= new_tag;
        end
    end

    assign rd_tag   = tags[idx];
    assign rd_valid = flags_q.valid[idx];
    assign rd_dirty = flags_q.dirty[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int NUM_LINES = 128,
    parameter int WORDS     = 8,
    parameter int WORD_W    = 32
) (
    input  logic                                    clk,
    input  logic [$clog2(NUM_LINES*WORDS)-1:0]      addr,
    input  logic                                    wr_en,
    input  logic [WORD_W/8-1:0]                     wr_be,
    input  logic [WORD_W-1:0]                       wr_data,
    output logic [WORD_W-1:0]                       rd_data
);

    localparam int DEPTH = NUM_LINES * WORDS;
    localparam int LANES = WORD_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                lane_mem[addr] <= wr_data[g*8 +: 8];
            end
        end

        assign rd_data[g*8 +: 8] = lane_mem[addr];
    end

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [WORD_W/8-1:0]           cpu_be,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic [WORD_W-1:0]             cpu_rdata,
    output logic                          cpu_ready,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic                          mem_ack,
    input  logic [WORD_W-1:0]             mem_rdata,
    output logic [$clog2(NUM_LINES)-1:0]  line_idx,
    input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_BYTES)-1:0] line_tag,
    input  logic                          line_valid,
    input  logic                          line_dirty,
    output dmc_pkg::tag_op_t              tag_op,
    output logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_BYTES)-1:0] tag_new,
    output logic [$clog2(LINE_BYTES/(WORD_W/8))-1:0] data_word,
    output logic                          data_we,
    output logic [WORD_W/8-1:0]           data_be,
    output logic [WORD_W-1:0]             data_wdata,
    input  logic [WORD_W-1:0]             data_rdata,
    output dmc_pkg::state_e               state_o,
    output logic                          req_we_o
);

    import dmc_pkg::*;

    localparam int BE_W   = WORD_W / 8;
    localparam int BSEL_W = $clog2(BE_W);
    localparam int OFFS_W = $clog2(LINE_BYTES);
    localparam int BEATS  = LINE_BYTES / BE_W;
    localparam int WSEL_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BEATS - 1);

    typedef struct packed {
        state_e                   state;
        logic                     we;
        logic [ADDR_W-1:BSEL_W]   addr;
        logic [BE_W-1:0]          be;
        logic [WORD_W-1:0]        wdata;
        logic [WSEL_W-1:0]        beat;
        logic [WORD_W-1:0]        rdata;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic              hit;
    logic              unused_lsb;

    assign unused_lsb = ^cpu_addr[BSEL_W-1:0];
    assign req_tag    = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign req_idx    = ctl_q.addr[OFFS_W +: IDX_W];
    assign req_word   = ctl_q.addr[BSEL_W +: WSEL_W];
    assign hit        = line_valid && (line_tag == req_tag);

    always_comb begin
        ctl_d      = ctl_q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        tag_op     = '0;
        data_word  = req_word;
        data_we    = 1'b0;
        data_be    = '0;
        data_wdata = ctl_q.wdata;

        case (ctl_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.state = ST_LOOKUP;
                    ctl_d.we    = cpu_we;
                    ctl_d.addr  = cpu_addr[ADDR_W-1:BSEL_W];
                    ctl_d.be    = cpu_be;
                    ctl_d.wdata = cpu_wdata;
                end
            end
            ST_LOOKUP: begin
                ctl_d.beat = '0;
                if (hit) begin
                    ctl_d.rdata = data_rdata;
                    ctl_d.state = ST_RESPOND;
                    if (ctl_q.we) begin
                        data_we          = 1'b1;
                        data_be          = ctl_q.be;
                        tag_op.set_dirty = 1'b1;
                    end
                end else if (line_valid && line_dirty) begin
                    ctl_d.state = ST_WRITEBACK;
                end else begin
                    ctl_d.state = ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {line_tag, req_idx, {OFFS_W{1'b0}}};
                data_word = ctl_q.beat;
                if (mem_ack) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.state = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                mem_req    = 1'b1;
                mem_addr   = {req_tag, req_idx, {OFFS_W{1'b0}}};
                data_word  = ctl_q.beat;
                data_we    = mem_ack;
                data_be    = '1;
                data_wdata = mem_rdata;
                if (mem_ack) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        tag_op.install = 1'b1;
                        ctl_d.state    = ST_LOOKUP;
                    end
                end
            end
            ST_RESPOND: begin
                cpu_ready   = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign line_idx  = req_idx;
    assign tag_new   = req_tag;
    assign cpu_rdata = ctl_q.rdata;
    assign state_o   = ctl_q.state;
    assign req_we_o  = ctl_q.we;

endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [WORD_W/8-1:0] cpu_be,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack
);

    localparam int BE_W   = WORD_W / 8;
    localparam int OFFS_W = $clog2(LINE_BYTES);
    localparam int BEATS  = LINE_BYTES / BE_W;
    localparam int WSEL_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  line_tag;
    logic [TAG_W-1:0]  tag_new;
    logic              line_valid;
    logic              line_dirty;
    dmc_pkg::tag_op_t  tag_op;
    logic [WSEL_W-1:0] data_word;
    logic              data_we;
    logic [BE_W-1:0]   data_be;
    logic [WORD_W-1:0] data_wdata;
    logic [WORD_W-1:0] data_rdata;
    dmc_pkg::state_e   fsm_state;
    logic              req_we;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W),
        .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_idx(line_idx), .line_tag(line_tag),
        .line_valid(line_valid), .line_dirty(line_dirty),
        .tag_op(tag_op), .tag_new(tag_new),
        .data_word(data_word), .data_we(data_we), .data_be(data_be),
        .data_wdata(data_wdata), .data_rdata(data_rdata),
        .state_o(fsm_state), .req_we_o(req_we)
    );

    dmc_tag_store #(
        .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(line_idx), .op(tag_op),
        .new_tag(tag_new), .rd_tag(line_tag),
        .rd_valid(line_valid), .rd_dirty(line_dirty)
    );

    dmc_data_store #(
        .NUM_LINES(NUM_LINES), .WORDS(BEATS), .WORD_W(WORD_W)
    ) u_data (
        .clk(clk), .addr({line_idx, data_word}),
        .wr_en(data_we), .wr_be(data_be), .wr_data(data_wdata),
        .rd_data(data_rdata)
    );

    assign mem_wdata = data_rdata;

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int WSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input dmc_pkg::state_e   fsm_state,
    input logic              req_we,
    input logic              line_dirty
);

    logic [WSEL_W-1:0] beat_q;
    localparam logic [WSEL_W-1:0] LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (!mem_req) begin
            beat_q <= '0;
        end else if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_ready && !mem_req));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r9_ready_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> ($past(fsm_state) == dmc_pkg::ST_LOOKUP));

    a_r4_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_we) |-> line_dirty);

    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFFS_W-1:0] == '0));

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r6_fetch_follows_copyout: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && (beat_q == LAST)) |=> (mem_req && !mem_we));

endmodule

bind dmc_top dmc_checker #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WSEL_W(WSEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .fsm_state(fsm_state),
    .req_we(req_we), .line_dirty(line_dirty)
);

// File: tb/test_dmc_top.sv
module test_dmc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2 clk = ~clk;

    dmc_top i_dmc_top (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wb_cnt = 0;
    int rf_cnt = 0;
    int beat = 0;
    int addr_jumps = 0;
    int double_ready = 0;
    logic ready_prev = 1'b0;
    logic [31:0] burst_addr = '0;
    logic [31:0] first_wb_addr = '0;
    logic [31:0] first_rf_addr = '0;

    logic [31:0] mem_arr [logic [31:0]];
    logic [31:0] shadow  [logic [31:0]];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_arr.exists(a)) return mem_arr[a];
        return pat(a);
    endfunction

    function automatic logic [31:0] shadow_read(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (shadow.exists(w)) return shadow[w];
        return pat(w);
    endfunction

    task automatic shadow_write(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] cur;
        cur = shadow_read(a);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) cur[b*8 +: 8] = d[b*8 +: 8];
        end
        shadow[{a[31:2], 2'b00}] = cur;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // memory model and port monitor, all on falling edges
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (beat == 0) burst_addr = mem_addr;
                else if (mem_addr != burst_addr) addr_jumps++;
                mem_ack = 1'b1;
                a = mem_addr + 32'(beat * 4);
                if (mem_we) begin
                    if (beat == 0) first_wb_addr = mem_addr;
                    mem_arr[a] = mem_wdata;
                    wb_cnt++;
                end else begin
                    if (beat == 0) first_rf_addr = mem_addr;
                    mem_rdata = mem_read(a);
                    rf_cnt++;
                end
                beat = (beat + 1) % 8;
            end else begin
                mem_ack = 1'b0;
                beat = 0;
            end
            if (cpu_ready && ready_prev) double_ready++;
            ready_prev = cpu_ready;
        end
    end

    task automatic do_access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                             input logic [31:0] wdata, input int exp_lat, input int exp_wb,
                             input int exp_rf, input string tag);
        int lat;
        logic [31:0] got;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_be    = be;
        cpu_wdata = wdata;
        wb_cnt    = 0;
        rf_cnt    = 0;
        lat       = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 100);
        got = cpu_rdata;
        cpu_req = 1'b0;
        check(lat == exp_lat, tag, "ready latency", 32'(lat), 32'(exp_lat));
        check(wb_cnt == exp_wb, tag, "copy-out beats", 32'(wb_cnt), 32'(exp_wb));
        check(rf_cnt == exp_rf, tag, "fetch beats", 32'(rf_cnt), 32'(exp_rf));
        if (we) begin
            shadow_write(addr, be, wdata);
        end else begin
            check(got == shadow_read(addr), tag, "read data", got, shadow_read(addr));
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [7:0]  lat;
        logic [3:0]  wb;
        logic [3:0]  rf;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_1004, 4'h0, 32'h0,         8'd11, 4'd0, 4'd8},
        '{1'b0, 32'h0000_1008, 4'h0, 32'h0,         8'd2,  4'd0, 4'd0},
        '{1'b1, 32'h0000_1008, 4'h3, 32'hDEAD_BEEF, 8'd2,  4'd0, 4'd0},
        '{1'b0, 32'h0000_1008, 4'h0, 32'h0,         8'd2,  4'd0, 4'd0},
        '{1'b0, 32'h0000_2008, 4'h0, 32'h0,         8'd19, 4'd8, 4'd8},
        '{1'b0, 32'h0000_1008, 4'h0, 32'h0,         8'd11, 4'd0, 4'd8},
        '{1'b1, 32'h0003_0044, 4'h8, 32'h1234_5678, 8'd11, 4'd0, 4'd8},
        '{1'b0, 32'h0003_0044, 4'h0, 32'h0,         8'd2,  4'd0, 4'd0},
        '{1'b0, 32'h0004_0040, 4'h0, 32'h0,         8'd19, 4'd8, 4'd8},
        '{1'b0, 32'h0003_0044, 4'h0, 32'h0,         8'd11, 4'd0, 4'd8},
        '{1'b0, 32'h0000_0FFC, 4'h0, 32'h0,         8'd11, 4'd0, 4'd8},
        '{1'b0, 32'hFFFF_FFE0, 4'h0, 32'h0,         8'd11, 4'd0, 4'd8},
        '{1'b1, 32'hFFFF_FFFC, 4'hF, 32'h0A0B_0C0D, 8'd2,  4'd0, 4'd0},
        '{1'b0, 32'hFFFF_FFE3, 4'h0, 32'h0,         8'd2,  4'd0, 4'd0},
        '{1'b1, 32'h0000_0FE4, 4'h4, 32'h0077_0000, 8'd19, 4'd8, 4'd8},
        '{1'b0, 32'hFFFF_FFFC, 4'h0, 32'h0,         8'd19, 4'd8, 4'd8}
    };
    localparam string TAG [NV] = '{
        "R5", "R3", "R4", "R4", "R6", "R8", "R7", "R7",
        "R6", "R8", "R2", "R8", "R4", "R2", "R7", "R6"
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0, "R1", "cpu_ready in reset", 32'(cpu_ready), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready == 1'b0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'h0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata,
                      int'(VEC[i].lat), int'(VEC[i].wb), int'(VEC[i].rf), TAG[i]);
        end

        // burst start addresses on a modified-line replacement
        do_access(1'b1, 32'h0000_5020, 4'hF, 32'h5555_AAAA, 11, 0, 8, "R7");
        do_access(1'b0, 32'h0000_7020, 4'h0, 32'h0, 19, 8, 8, "R6");
        check(first_wb_addr == 32'h0000_5020, "R6", "copy-out line address", first_wb_addr, 32'h0000_5020);
        check(first_rf_addr == 32'h0000_7020, "R2", "fetch line address", first_rf_addr, 32'h0000_7020);

        // modified line lost across reset: no copy-out, fetch again
        do_access(1'b1, 32'h0000_0FE0, 4'hF, 32'h9999_8888, 11, 0, 8, "R7");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        shadow.delete(32'h0000_0FE0);
        do_access(1'b0, 32'h0000_0FE0, 4'h0, 32'h0, 11, 0, 8, "R1");
        do_access(1'b0, 32'hFFFF_FFFC, 4'h0, 32'h0, 11, 0, 8, "R1");

        repeat (3) @(negedge clk);
        check(addr_jumps == 0, "R10", "address changes inside burst", 32'(addr_jumps), 32'h0);
        check(double_ready == 0, "R9", "ready high two cycles", 32'(double_ready), 32'h0);
        finish_run();
    end

endmodule